// File: doc/BRIEF.md
# Page-Translated DMA Channel Engine

This block moves data between peripheral devices and system memory on behalf of several DMA channels. Each channel owns three software registers: a mode word (enable, direction and three status flags), a byte count and a device-side start address. A device raises its request line with a direction and a byte length. The engine then serves one request at a time. It first checks that the channel is enabled and set for the same direction. It then walks the device address one 4096-byte page at a time. For each page it reads an 8-byte translation entry from a table in system memory and moves 32-bit words to or from the translated physical address over a valid/ready memory master port.

Translation uses two shared registers. The table base gives where the table starts. The table limit, in bytes, bounds how many entries may be used. A request that breaks the channel rules moves no data. It sets a memory-error flag in the channel and a sticky bit for that channel in a shared non-maskable-interrupt source register. Every request, whether served or rejected, ends with a one-cycle done pulse on the requesting channel's line.

Top module: `pgdma_engine`

## Requirements
- R1: After reset, every channel mode, count and device-address register, the table base, the table limit and the interrupt-source register read zero, and `mem_valid`, `done` and `dev_beat` are low.
- R2: `cfg_addr` is `{global, channel[1:0], select[1:0]}`. With global=0, select 0/1/2 give the channel's mode, count and device address. With global=1, select 0/1/2 give the table base, the table limit and the interrupt-source register. Select 3 reads zero. The mode, count, device-address, base and limit registers read back what was written. Writes to the interrupt-source register have no effect.
- R3: Mode bit 0 is enable, and mode bit 1 set means memory-to-device. `req_write`=1 asks for device-to-memory. A request on a disabled channel, or one whose direction disagrees with bit 1, makes no memory access. It sets mode bit 9 and sets bit n of the interrupt-source register for channel n. That bit stays set until reset.
- R4: At the start of every request, mode bits 8, 9 and 10 of the granted channel are cleared before anything else is decided.
- R5: The length moved is the smaller of the requested length and the count register, with its two low bits dropped (whole 32-bit words). At the end, the count drops by the bytes actually moved and mode bit 8 (terminal count) is set.
- R6: Each page touched costs exactly one table read. That read is at (base + 8 × (device address / 4096)) with bit 31 forced to zero. The first 32-bit word of the entry is the frame, and the word goes to frame + (device address mod 4096). No word access crosses a page without a new table read.
- R7: When the page index reaches or exceeds limit / 8, the transfer stops without reading that entry. Words already moved stay moved, the count drops only by them, and the terminal-count flag is still set.
- R8: Device-to-memory requests write successive `dev_wdata` words to memory. Memory-to-device requests read memory and present each word on `dev_rdata` in a cycle where `dev_beat` is high.
- R9: Only one request is served at a time. When several are pending, the lowest-numbered channel wins. `done` is a one-hot, one-cycle pulse for the served channel, and the memory port is idle while it is high.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_we` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select {global, channel, select} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 4 | Per-channel transfer request, held until done |
| req_write | input | 4 | Per-channel direction: 1 = device to memory |
| req_len | input | 128 | Per-channel requested byte length, 32 bits each |
| done | output | 4 | One-cycle completion or rejection pulse per channel |
| dev_beat | output | 1 | A word is taken from or handed to the device |
| dev_wdata | input | 32 | Word from the served device |
| dev_rdata | output | 32 | Word to the served device, valid with dev_beat |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request (read data valid too) |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready on reads |

## Verification
The bench aims at a transfer that starts eight bytes before a page end. A design that does not split there would write the last words past the first frame instead of into the second one. It also targets a start index equal to limit / 8 and a transfer that runs into the limit partway through. An off-by-one comparison would either fetch an entry beyond the table or drop a page that is allowed. It also probes a table base with bit 31 set, which a design without the mask would send to an unmapped address. The remaining targets are the count clamp with odd low bits, flags left over from an earlier request that must vanish, a mismatched direction that must not touch memory, two channels requesting at once, and a memory that stalls every other cycle while the address must stay put.

// File: rtl/pgdma_engine.sv
module pgdma_engine #(
  parameter int NCH     = 4,
  parameter int PG_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [$clog2(NCH)+2:0] cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NCH-1:0]      req_valid,
  input  logic [NCH-1:0]      req_write,
  input  logic [NCH*32-1:0]   req_len,
  output logic [NCH-1:0]      done,
  output logic                dev_beat,
  input  logic [31:0]         dev_wdata,
  output logic [31:0]         dev_rdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [31:0]         mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata
);
  localparam int CW = $clog2(NCH);
  localparam int ENT_SH = 3;
  localparam logic [31:0] PG_MASK = (32'd1 << PG_BITS) - 32'd1;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PAGE, S_FETCH, S_XFER, S_DONE} st_t;
  st_t st;

  logic [31:0] mode_q [NCH];
  logic [31:0] count_q [NCH];
  logic [31:0] dadr_q [NCH];
  logic [31:0] base_q, limit_q;
  logic [NCH-1:0] nmi_q;

  logic [CW-1:0] ch_q, gnt;
  logic          wr_q;
  logic [31:0]   len_q, rem_q, cur_q, moved_q, frame_q;

  logic          cg;
  logic [CW-1:0] cch;
  logic [1:0]    csel;
  assign cg   = cfg_addr[CW+2];
  assign cch  = cfg_addr[CW+1:2];
  assign csel = cfg_addr[1:0];

  always_comb begin
    cfg_rdata = '0;
    if (cg) begin
      case (csel)
        2'd0: cfg_rdata = base_q;
        2'd1: cfg_rdata = limit_q;
        2'd2: cfg_rdata = 32'(nmi_q);
        default: cfg_rdata = '0;
      endcase
    end else begin
      case (csel)
        2'd0: cfg_rdata = mode_q[cch];
        2'd1: cfg_rdata = count_q[cch];
        2'd2: cfg_rdata = dadr_q[cch];
        default: cfg_rdata = '0;
      endcase
    end
  end

  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req_valid[i]) gnt = i[CW-1:0];
  end

  logic        chan_ok, over, in_fetch, page_end;
  logic [31:0] len_eff, page_idx, entry_addr, phys_addr;

  assign chan_ok    = mode_q[ch_q][0] && (wr_q == !mode_q[ch_q][1]);
  assign len_eff    = ((len_q > count_q[ch_q]) ? count_q[ch_q] : len_q) & ~32'd3;
  assign page_idx   = cur_q >> PG_BITS;
  assign over       = page_idx >= (limit_q >> ENT_SH);
  assign entry_addr = (base_q + (page_idx << ENT_SH)) & 32'h7FFF_FFFF;
  assign phys_addr  = frame_q + (cur_q & PG_MASK);
  assign page_end   = ((cur_q + 32'd4) & PG_MASK) == 32'd0;
  assign in_fetch   = (st == S_FETCH);

  assign mem_valid = in_fetch || (st == S_XFER);
  assign mem_we    = (st == S_XFER) && wr_q;
  assign mem_addr  = in_fetch ? entry_addr : phys_addr;
  assign mem_wdata = dev_wdata;
  assign dev_beat  = (st == S_XFER) && mem_ready;
  assign dev_rdata = mem_rdata;

  always_comb begin
    done = '0;
    if (st == S_DONE) done[ch_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ch_q    <= '0;
      wr_q    <= 1'b0;
      len_q   <= '0;
      rem_q   <= '0;
      cur_q   <= '0;
      moved_q <= '0;
      frame_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (|req_valid) begin
          ch_q  <= gnt;
          wr_q  <= req_write[gnt];
          len_q <= req_len[gnt*32 +: 32];
          st    <= S_CHECK;
        end
        S_CHECK: if (chan_ok) begin
          rem_q   <= len_eff;
          cur_q   <= dadr_q[ch_q] & ~32'd3;
          moved_q <= '0;
          st      <= S_PAGE;
        end else begin
          st <= S_DONE;
        end
        S_PAGE: st <= (rem_q == 32'd0 || over) ? S_DONE : S_FETCH;
        S_FETCH: if (mem_ready) begin
          frame_q <= mem_rdata;
          st      <= S_XFER;
        end
        S_XFER: if (mem_ready) begin
          cur_q   <= cur_q + 32'd4;
          rem_q   <= rem_q - 32'd4;
          moved_q <= moved_q + 32'd4;
          if (rem_q == 32'd4 || page_end) st <= S_PAGE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        mode_q[i]  <= '0;
        count_q[i] <= '0;
        dadr_q[i]  <= '0;
      end
      base_q  <= '0;
      limit_q <= '0;
      nmi_q   <= '0;
    end else begin
      if (cfg_we) begin
        if (cg) begin
          if (csel == 2'd0) base_q  <= cfg_wdata;
          if (csel == 2'd1) limit_q <= cfg_wdata;
        end else begin
          if (csel == 2'd0) mode_q[cch]  <= cfg_wdata;
          if (csel == 2'd1) count_q[cch] <= cfg_wdata;
          if (csel == 2'd2) dadr_q[cch]  <= cfg_wdata;
        end
      end
      if (st == S_IDLE && |req_valid) mode_q[gnt][10:8] <= 3'b000;
      if (st == S_CHECK && !chan_ok) begin
        mode_q[ch_q][9] <= 1'b1;
        nmi_q[ch_q]     <= 1'b1;
      end
      if (st == S_PAGE && (rem_q == 32'd0 || over)) begin
        mode_q[ch_q][8] <= 1'b1;
        count_q[ch_q]   <= count_q[ch_q] - moved_q;
      end
    end
  end
endmodule

// File: rtl/pgdma_engine_chk.sv
module pgdma_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] done,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [31:0]    mem_addr,
  input logic [NCH-1:0] nmi,
  input logic           fetch,
  input logic           dev_beat
);
  a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

  a_r9_done_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> !mem_valid);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  a_r3_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((nmi & ~$past(nmi)) | ($past(nmi) & ~nmi)) == (nmi & ~$past(nmi)));

  a_r6_entry_bit31_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mem_valid) |-> (!mem_addr[31] && !mem_we));

  a_r8_beat_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    dev_beat |-> (mem_valid && mem_ready && !fetch));
endmodule

bind pgdma_engine pgdma_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .nmi(nmi_q), .fetch(in_fetch), .dev_beat(dev_beat)
);

// File: tb/test_pgdma_engine.sv
module test_pgdma_engine;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [3:0]  req_valid = 0, req_write = 0, done;
  logic [127:0] req_len = 0;
  logic        dev_beat, mem_valid, mem_ready, mem_we;
  logic [31:0] dev_wdata, dev_rdata, mem_addr, mem_wdata, mem_rdata;

  pgdma_engine i_pgdma_engine (.*);

  logic [31:0] bmem [0:4095];
  logic [31:0] rx [0:255];
  int beat_cnt = 0, rx_n = 0, accesses = 0, tbl_reads = 0, stray = 0;
  logic stall_en = 0, tog = 0;
  logic poke_en = 0;
  logic [31:0] poke_a = 0, poke_d = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  assign mem_rdata = (mem_addr[31:14] == 0) ? bmem[mem_addr[13:2]] : 32'hBAD0_0000;
  assign mem_ready = stall_en ? tog : 1'b1;
  assign dev_wdata = 32'hA500_0000 + beat_cnt;

  initial for (int i = 0; i < 4096; i++) bmem[i] = '0;

  always @(posedge clk) begin
    tog <= ~tog;
    if (poke_en) bmem[poke_a[13:2]] <= poke_d;
    if (mem_valid && mem_ready) begin
      accesses <= accesses + 1;
      if (mem_we) begin
        if (mem_addr[31:14] == 0) bmem[mem_addr[13:2]] <= mem_wdata;
        else stray <= stray + 1;
      end else if (mem_addr >= 32'h1000 && mem_addr < 32'h2000) begin
        tbl_reads <= tbl_reads + 1;
      end
    end
    if (dev_beat) begin
      if (mem_we) beat_cnt <= beat_cnt + 1;
      else begin rx[rx_n[7:0]] <= dev_rdata; rx_n <= rx_n + 1; end
    end
  end

  function automatic logic [4:0] ca(int ch, int sel);
    return {1'b0, 2'(ch), 2'(sel)};
  endfunction
  function automatic logic [4:0] ga(int sel);
    return {1'b1, 2'b00, 2'(sel)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(logic [31:0] a, logic [31:0] d);
    poke_a = a; poke_d = d; poke_en = 1;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_done(output logic [3:0] dv);
    int t = 0;
    dv = 0;
    while (done == 0 && t < 5000) begin @(negedge clk); t++; end
    dv = done;
  endtask

  task automatic run_req(int ch, logic w, logic [31:0] len, output logic [3:0] dv);
    req_len[ch*32 +: 32] = len; req_write[ch] = w; req_valid[ch] = 1;
    @(negedge clk);
    wait_done(dv);
    req_valid[ch] = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) begin rd(ca(c, s), v); chk("R1 channel reg reset", v, 0); end
    for (int s = 0; s < 4; s++) begin rd(ga(s), v); chk("R1 global reg reset", v, 0); end
    chk("R1 idle outputs", {28'b0, done, mem_valid, dev_beat} , 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(ca(0, 2), 32'h1234_5678); rd(ca(0, 2), v); chk("R2 devaddr readback", v, 32'h1234_5678);
    wr(ca(3, 1), 32'h0000_00AC); rd(ca(3, 1), v); chk("R2 count readback", v, 32'hAC);
    wr(ga(1), 32'h40); rd(ga(1), v); chk("R2 limit readback", v, 32'h40);
    wr(ga(0), 32'h1000); rd(ga(0), v); chk("R2 base readback", v, 32'h1000);
    wr(ga(2), 32'hF); rd(ga(2), v); chk("R2 nmi write ignored", v, 0);
    rd(ca(0, 3), v); chk("R2 select3 reads zero", v, 0);
  endtask

  task automatic t_dev_to_mem_split;
    logic [31:0] v; logic [3:0] dv; int b, tr;
    wr(ca(1, 0), 32'h1); wr(ca(1, 1), 32'h100); wr(ca(1, 2), 32'hFF8);
    b = beat_cnt; tr = tbl_reads;
    run_req(1, 1, 16, dv);
    chk("R9 done ch1", 32'(dv), 32'h2);
    chk("R6 R8 word0 in frame0", bmem[32'h2FF8 >> 2], 32'hA500_0000 + b);
    chk("R6 R8 word1 in frame0", bmem[32'h2FFC >> 2], 32'hA500_0001 + b);
    chk("R6 word2 in frame1", bmem[32'h3000 >> 2], 32'hA500_0002 + b);
    chk("R6 word3 in frame1", bmem[32'h3004 >> 2], 32'hA500_0003 + b);
    chk("R6 one table read per page", tbl_reads - tr, 2);
    rd(ca(1, 1), v); chk("R5 count reduced", v, 32'hF0);
    rd(ca(1, 0), v); chk("R5 tc flag set", v, 32'h101);
    rd(ca(1, 2), v); chk("R5 devaddr unchanged", v, 32'hFF8);
  endtask

  task automatic t_mem_to_dev;
    logic [31:0] v; logic [3:0] dv; int s;
    poke(32'h3010, 32'h1111_2222); poke(32'h3014, 32'h3333_4444);
    wr(ca(2, 0), 32'h3); wr(ca(2, 1), 32'h40); wr(ca(2, 2), 32'h1010);
    s = rx_n;
    run_req(2, 0, 8, dv);
    chk("R8 rx word0", rx[s[7:0]], 32'h1111_2222);
    chk("R8 rx word1", rx[8'(s + 1)], 32'h3333_4444);
    rd(ca(2, 1), v); chk("R5 count after read", v, 32'h38);
    rd(ca(2, 0), v); chk("R5 tc after read", v, 32'h103);
  endtask

  task automatic t_clamp;
    logic [31:0] v; logic [3:0] dv; int s;
    wr(ca(2, 1), 32'hC);
    s = rx_n;
    run_req(2, 0, 32'hB, dv);
    chk("R5 clamp words moved", rx_n - s, 2);
    rd(ca(2, 1), v); chk("R5 clamp count left", v, 32'h4);
  endtask

  task automatic t_reject;
    logic [31:0] v; logic [3:0] dv; int a;
    a = accesses;
    run_req(0, 1, 8, dv);
    chk("R3 disabled done", 32'(dv), 32'h1);
    chk("R3 disabled no access", accesses - a, 0);
    rd(ca(0, 0), v); chk("R3 disabled mem err", v, 32'h200);
    rd(ga(2), v); chk("R3 nmi bit0", v, 32'h1);
    wr(ca(3, 0), 32'h3);
    a = accesses;
    run_req(3, 1, 8, dv);
    chk("R3 dir mismatch no access", accesses - a, 0);
    rd(ca(3, 0), v); chk("R3 dir mismatch flag", v, 32'h203);
    rd(ga(2), v); chk("R3 nmi bits 0 and 3", v, 32'h9);
    wr(ga(2), 32'h0); rd(ga(2), v); chk("R2 R3 nmi kept after write", v, 32'h9);
  endtask

  task automatic t_flag_clear;
    logic [31:0] v; logic [3:0] dv;
    wr(ca(3, 0), 32'h703); wr(ca(3, 1), 32'h10); wr(ca(3, 2), 32'h0);
    run_req(3, 0, 4, dv);
    rd(ca(3, 0), v); chk("R4 old flags cleared", v, 32'h103);
  endtask

  task automatic t_limit;
    logic [31:0] v; logic [3:0] dv; int a, b, tr;
    wr(ca(1, 2), 32'h8000);
    a = accesses;
    run_req(1, 1, 8, dv);
    chk("R7 index at limit no access", accesses - a, 0);
    rd(ca(1, 1), v); chk("R7 count unchanged", v, 32'hF0);
    rd(ca(1, 0), v); chk("R7 tc still set", v, 32'h101);
    wr(ga(1), 32'h10); wr(ca(1, 2), 32'h1FF8);
    b = beat_cnt; tr = tbl_reads;
    run_req(1, 1, 16, dv);
    chk("R7 partial word0", bmem[32'h3FF8 >> 2], 32'hA500_0000 + b);
    chk("R7 partial word1", bmem[32'h3FFC >> 2], 32'hA500_0001 + b);
    chk("R7 beyond entry not fetched", tbl_reads - tr, 1);
    chk("R7 beyond frame untouched", bmem[32'h2800 >> 2], 0);
    rd(ca(1, 1), v); chk("R7 count by moved only", v, 32'hE8);
    wr(ga(1), 32'h40);
  endtask

  task automatic t_bit31;
    logic [3:0] dv; int b, sr;
    wr(ga(0), 32'h8000_1000); wr(ca(1, 2), 32'h4);
    b = beat_cnt; sr = stray;
    run_req(1, 1, 4, dv);
    chk("R6 bit31 masked", bmem[32'h2004 >> 2], 32'hA500_0000 + b);
    chk("R6 no stray write", stray - sr, 0);
  endtask

  task automatic t_stall;
    logic [3:0] dv; int b;
    stall_en = 1;
    wr(ca(1, 2), 32'hFFC);
    b = beat_cnt;
    run_req(1, 1, 8, dv);
    stall_en = 0;
    chk("R10 stalled word0", bmem[32'h2FFC >> 2], 32'hA500_0000 + b);
    chk("R10 stalled word1", bmem[32'h3000 >> 2], 32'hA500_0001 + b);
  endtask

  task automatic t_priority;
    logic [3:0] dv;
    wr(ca(1, 2), 32'h100); wr(ca(2, 1), 32'h40); wr(ca(2, 2), 32'h1010);
    req_len[32 +: 32] = 4; req_len[64 +: 32] = 4;
    req_write[1] = 1; req_write[2] = 0;
    req_valid[1] = 1; req_valid[2] = 1;
    @(negedge clk);
    wait_done(dv);
    chk("R9 lowest channel first", 32'(dv), 32'h2);
    req_valid[1] = 0;
    @(negedge clk);
    wait_done(dv);
    chk("R9 second channel next", 32'(dv), 32'h4);
    req_valid[2] = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_regs;
    poke(32'h1000, 32'h2000); poke(32'h1004, 32'hFFFF_FFFF);
    poke(32'h1008, 32'h3000); poke(32'h1010, 32'h2800);
    t_dev_to_mem_split;
    t_mem_to_dev;
    t_clamp;
    t_reject;
    t_flag_clear;
    t_limit;
    t_bit31;
    t_stall;
    t_priority;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule